// File: doc/BRIEF.md
# Snooping Line Coherence Controller

This block holds the coherence state of one line in a private cache that shares a bus with other caches. Each cycle it takes a processor read or write request on the line, a snooped transaction from another cache, and the bus shared signal. From these it produces three things: the bus transaction this cache must issue, a flush strobe that tells the data path to supply the dirty line, and the state the line takes at the next clock edge. The state is held in a register inside the block. Each bus transaction is treated as finishing within the cycle that issues it.

Two elaboration parameters pick the protocol. `USE_MESI` chooses between a four-state protocol that includes an Exclusive (clean, sole-owner) state and a three-state protocol without it. `USE_UPGRADE` applies only in three-state mode. It decides whether a write to a Shared line sends a dataless upgrade or a full read-exclusive that fetches the line from memory again. In four-state mode a write to a Shared line always sends an upgrade. Tag match, data storage, replacement and bus arbitration belong to the surrounding cache.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: While `rst_ni` is low, the line state is Invalid and both `bus_op_o` and `flush_o` are 0. State codes: Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A processor read of an Invalid line issues a bus read. Bus and snoop op codes: none=0, read=1, read-exclusive=2, upgrade=3. In four-state mode the line goes to Exclusive if `shared_i` is low and to Shared if it is high. In three-state mode it goes to Shared.
- R3: A processor read of a Shared, Exclusive or Modified line, or a cycle with no request and no snoop, issues nothing and leaves the state unchanged.
- R4: A processor write to an Invalid line issues a read-exclusive, and the line goes to Modified.
- R5: A processor write to a Shared line goes to Modified. It issues an upgrade in four-state mode, and in three-state mode when `USE_UPGRADE` is 1. It issues a read-exclusive in three-state mode when `USE_UPGRADE` is 0.
- R6: A processor write to an Exclusive or Modified line issues nothing, and the line ends in Modified.
- R7: A snooped read of a Modified line asserts `flush_o` and moves the line to Shared. A snooped read of an Exclusive line moves it to Shared without a flush. A snooped read of a Shared or Invalid line changes nothing.
- R8: A snooped read-exclusive or upgrade moves any line to Invalid. It asserts `flush_o` only when the line was Modified.
- R9: When a snoop arrives in the same cycle as a processor request, the snoop is handled. The processor request is ignored: no bus op is issued and it has no effect on the state.
- R10: In three-state mode the line never enters Exclusive.
- R11: A processor read and write in the same cycle are handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| proc_rd_i | input | 1 | Processor read request on the line |
| proc_wr_i | input | 1 | Processor write request on the line |
| snp_op_i | input | 2 | Snooped transaction from another cache (0 when none) |
| shared_i | input | 1 | Bus shared signal, sampled on a read miss |
| bus_op_o | output | 2 | Bus transaction to issue this cycle |
| flush_o | output | 1 | Supply the dirty line to the bus |
| next_state_o | output | 2 | State the line takes at the next edge |
| state_o | output | 2 | Current line state |

## Verification
The bench drives three instances side by side: four-state, three-state with upgrade, and three-state with refetch. From every reachable starting state it sweeps every mix of processor request, snoop op and shared level. Fills with `shared_i` low expose a three-state design that leaks into Exclusive, and a four-state design that ignores the shared signal and always fills Shared. Writes to Shared lines separate upgrade from refetch, so a swapped parameter decode shows up as the wrong bus op. Snoops that collide with processor requests show whether a design lets the processor win or issues both ops. Snoops that hit Exclusive lines catch a spurious flush or a missed downgrade.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_RDX  = 2'd2,
    OP_UPG  = 2'd3
  } bus_op_e;
endpackage

// File: rtl/coh_proc_side.sv
module coh_proc_side
  import coh_pkg::*;
#(
  parameter bit USE_MESI    = 1'b1,
  parameter bit USE_UPGRADE = 1'b1
) (
  input  line_st_e st_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     shared_i,
  output bus_op_e  op_o,
  output line_st_e nxt_o
);
  bus_op_e  shared_wr_op;
  line_st_e fill_st;

  // write to a Shared line: dataless upgrade or full refetch
  generate
    if (USE_MESI || USE_UPGRADE) begin : g_upg
      assign shared_wr_op = OP_UPG;
    end else begin : g_rdx
      assign shared_wr_op = OP_RDX;
    end
  endgenerate

  assign fill_st = (USE_MESI && !shared_i) ? ST_E : ST_S;

  always_comb begin
    op_o  = OP_NONE;
    nxt_o = st_i;
    if (wr_i) begin
      nxt_o = ST_M;
      unique case (st_i)
        ST_I:    op_o = OP_RDX;
        ST_S:    op_o = shared_wr_op;
        default: op_o = OP_NONE;
      endcase
    end else if (rd_i && st_i == ST_I) begin
      op_o  = OP_RD;
      nxt_o = fill_st;
    end
  end
endmodule

// File: rtl/coh_snoop_side.sv
module coh_snoop_side
  import coh_pkg::*;
(
  input  line_st_e st_i,
  input  bus_op_e  snp_op_i,
  output logic     flush_o,
  output line_st_e nxt_o
);
  always_comb begin
    flush_o = 1'b0;
    nxt_o   = st_i;
    unique case (snp_op_i)
      OP_RD: begin
        if (st_i == ST_M || st_i == ST_E) nxt_o = ST_S;
        flush_o = (st_i == ST_M);
      end
      OP_RDX, OP_UPG: begin
        nxt_o   = ST_I;
        flush_o = (st_i == ST_M);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter bit USE_MESI    = 1'b1,
  parameter bit USE_UPGRADE = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       proc_rd_i,
  input  logic       proc_wr_i,
  input  logic [1:0] snp_op_i,
  input  logic       shared_i,
  output logic [1:0] bus_op_o,
  output logic       flush_o,
  output logic [1:0] next_state_o,
  output logic [1:0] state_o
);
  line_st_e st_q, st_d, proc_nxt, snp_nxt;
  bus_op_e  proc_op, snp_op;
  logic     snp_flush, snp_act;

  assign snp_op  = bus_op_e'(snp_op_i);
  assign snp_act = (snp_op != OP_NONE);

  coh_proc_side #(
    .USE_MESI   (USE_MESI),
    .USE_UPGRADE(USE_UPGRADE)
  ) u_proc (
    .st_i    (st_q),
    .rd_i    (proc_rd_i),
    .wr_i    (proc_wr_i),
    .shared_i(shared_i),
    .op_o    (proc_op),
    .nxt_o   (proc_nxt)
  );

  coh_snoop_side u_snoop (
    .st_i    (st_q),
    .snp_op_i(snp_op),
    .flush_o (snp_flush),
    .nxt_o   (snp_nxt)
  );

  // snoop wins; the processor retries next cycle
  assign st_d         = snp_act ? snp_nxt : proc_nxt;
  assign bus_op_o     = snp_act ? OP_NONE : proc_op;
  assign flush_o      = snp_act & snp_flush;
  assign next_state_o = st_d;
  assign state_o      = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_I;
    else         st_q <= st_d;
  end

  AST_FLUSH_ONLY_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (state_o == ST_M && snp_act)); // R7
  AST_SNOOP_BLOCKS_PROC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_act |-> (bus_op_o == OP_NONE)); // R9
  AST_WRITE_ENDS_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_wr_i && !snp_act) |=> (state_o == ST_M)); // R6
  AST_EXCL_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_E && proc_wr_i && !snp_act) |-> (bus_op_o == OP_NONE)); // R6
  AST_SNOOP_INVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_op == OP_RDX || snp_op == OP_UPG) |=> (state_o == ST_I)); // R8
  AST_NO_EXCL_IN_MSI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !USE_MESI |-> (state_o != ST_E)); // R10
  AST_REFETCH_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!USE_MESI && !USE_UPGRADE) |-> (bus_op_o != OP_UPG)); // R5
endmodule

// File: tb/snoop_coh_ctrl_tb.sv
module snoop_coh_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd = 1'b0, wr = 1'b0, sh = 1'b0;
  logic [1:0] sop = 2'd0;
  logic [1:0] bus [3];
  logic       fl  [3];
  logic [1:0] nx  [3];
  logic [1:0] st  [3];
  int         exp_st [3];
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_coh_ctrl #(.USE_MESI(1'b1), .USE_UPGRADE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .proc_rd_i(rd), .proc_wr_i(wr), .snp_op_i(sop),
    .shared_i(sh), .bus_op_o(bus[0]), .flush_o(fl[0]), .next_state_o(nx[0]), .state_o(st[0]));
  snoop_coh_ctrl #(.USE_MESI(1'b0), .USE_UPGRADE(1'b1)) u_dut_msi_upg (
    .clk_i(clk), .rst_ni(rst_ni), .proc_rd_i(rd), .proc_wr_i(wr), .snp_op_i(sop),
    .shared_i(sh), .bus_op_o(bus[1]), .flush_o(fl[1]), .next_state_o(nx[1]), .state_o(st[1]));
  snoop_coh_ctrl #(.USE_MESI(1'b0), .USE_UPGRADE(1'b0)) u_dut_msi_rdx (
    .clk_i(clk), .rst_ni(rst_ni), .proc_rd_i(rd), .proc_wr_i(wr), .snp_op_i(sop),
    .shared_i(sh), .bus_op_o(bus[2]), .flush_o(fl[2]), .next_state_o(nx[2]), .state_o(st[2]));

  task automatic chk(input string req, input string what, input int k, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s dut%0d %s: actual %0d expected %0d", req, k, what, act, exp);
    end
  endtask

  // expected behaviour from the requirements; states I0 S1 E2 M3, ops none0 rd1 rdx2 upg3
  task automatic model(input int k, input int s, output int eop, output int efl,
                       output int ens, output string tag);
    bit mesi = (k == 0);
    bit upg  = (k == 1);
    eop = 0; efl = 0; ens = s;
    if (sop != 0) begin
      tag = (rd || wr) ? "R9" : (sop == 1 ? "R7" : "R8");
      if (sop == 1) begin
        efl = (s == 3);
        if (s >= 2) ens = 1;
      end else begin
        efl = (s == 3);
        ens = 0;
      end
    end else if (wr) begin
      ens = 3;
      if (s == 0) begin eop = 2; tag = "R4"; end
      else if (s == 1) begin eop = (mesi || upg) ? 3 : 2; tag = "R5"; end
      else tag = "R6";
      if (rd) tag = "R11";
    end else if (rd && s == 0) begin
      eop = 1; ens = (mesi && !sh) ? 2 : 1; tag = "R2";
    end else begin
      tag = "R3";
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [1:0] so, input logic s);
    int eop[3], efl[3], ens[3];
    string tag[3];
    @(negedge clk);
    rd = r; wr = w; sop = so; sh = s;
    #1;
    for (int k = 0; k < 3; k++) begin
      model(k, exp_st[k], eop[k], efl[k], ens[k], tag[k]);
      chk(tag[k], "bus_op", k, int'(bus[k]), eop[k]);
      chk(tag[k], "flush", k, int'(fl[k]), efl[k]);
      chk(tag[k], "next_state", k, int'(nx[k]), ens[k]);
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++) begin
      chk(tag[k], "state", k, int'(st[k]), ens[k]);
      if (k != 0) chk("R10", "not_excl", k, int'(st[k] == 2'd2), 0);
      exp_st[k] = ens[k];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; rd = 0; wr = 0; sop = 0; sh = 0;
    #1;
    for (int k = 0; k < 3; k++) begin
      chk("R1", "state", k, int'(st[k]), 0);
      chk("R1", "bus_op", k, int'(bus[k]), 0);
      chk("R1", "flush", k, int'(fl[k]), 0);
      exp_st[k] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    for (int setup = 0; setup < 4; setup++) begin
      for (int combo = 0; combo < 32; combo++) begin
        do_reset();
        // setup: 0 none, 1 read shared, 2 read not shared, 3 write
        case (setup)
          1: step(1'b1, 1'b0, 2'd0, 1'b1);
          2: step(1'b1, 1'b0, 2'd0, 1'b0);
          3: step(1'b0, 1'b1, 2'd0, 1'b0);
          default: ;
        endcase
        step(combo[0], combo[1], combo[3:2], combo[4]);
      end
    end
    // back-to-back chain: write, remote read, remote upgrade, local read miss
    do_reset();
    step(1'b0, 1'b1, 2'd0, 1'b0);
    step(1'b0, 1'b0, 2'd1, 1'b0);
    step(1'b0, 1'b0, 2'd3, 1'b0);
    step(1'b1, 1'b0, 2'd0, 1'b0);
    step(1'b0, 1'b1, 2'd0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule